// File: doc/BRIEF.md
# Paged Program Counter with Circular Return Stack

This block holds the 13-bit instruction address of a small 8-bit core that fetches 14-bit instruction words. Each cycle the core gives it one operation: step to the next address, branch or call within a 2K-word page, return, load the low address byte from the data path, or take an interrupt. The block computes the next address and keeps subroutine return addresses on an 8-deep hardware stack.

The upper five address bits are never loaded directly. They come from a separate page-holding latch that the core writes from its data bus. Branches and calls carry 11 address bits and take the two page bits from the latch. A low-byte write takes all five upper bits from the latch. Returns restore a full 13-bit address from the stack and leave the latch untouched.

The return stack is circular. Once it is full, a further push silently overwrites the oldest entry and no overflow is reported. Its pointer is not visible outside the block.

Top module: `prog_ctr_unit`

## Requirements
- R1: While rst_ni is low, pc_o is 0x000, the page latch is 0 and the stack pointer is 0. Every stack entry is also 0, so a return taken right after reset gives pc_o = 0x000.
- R2: op_i = 0 (step) sets pc_o to pc_o+1 on the next cycle. The count wraps from 0x1FFF to 0x000.
- R3: op_i = 1 (branch) sets pc_o to {latch[4:3], tgt_i[10:0]}.
- R4: op_i = 2 (call) sets pc_o to {latch[4:3], tgt_i[10:0]} and pushes pc_o+1, which wraps within 13 bits.
- R5: op_i = 3 (return) sets pc_o to the most recently pushed address that has not yet been popped, with all 13 bits restored.
- R6: op_i = 4 (low-byte write) sets pc_o to {latch[4:0], data_i[7:0]}.
- R7: op_i = 5 (interrupt) pushes the current pc_o unchanged and sets pc_o to 0x004.
- R8: When latch_we_i is high, the latch loads data_i[4:0] at the clock edge. An operation in the same cycle still uses the old latch value. Pushes and pops never change the latch.
- R9: The stack holds 8 entries. The ninth push overwrites the first entry, the tenth push overwrites the second, and so on. After ten pushes, pops return pushes 10 down to 3, and then push 10 and push 9 again.
- R10: op_i = 6 or 7 holds pc_o and leaves the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code for this cycle |
| tgt_i | input | 11 | In-page target for branch and call |
| data_i | input | 8 | Data value for the low-byte write and the latch load |
| latch_we_i | input | 1 | Loads the page latch from data_i[4:0] |
| pc_o | output | 13 | Current program counter |

## Verification
The hardest situation to reach is stack wrap-around. The pointer is hidden, so the only evidence of an overwrite is which address a later return produces. The bench drives ten calls, each from a distinct address, and then performs ten returns. It compares every returned address against a model of an 8-slot circular buffer, so any lost or misordered entry shows up. Latch independence is shown by checking the upper pc_o bits after a low-byte write that follows a run of pushes and pops.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    PC_OP_INC  = 3'd0,
    PC_OP_JMP  = 3'd1,
    PC_OP_CALL = 3'd2,
    PC_OP_RET  = 3'd3,
    PC_OP_WRLO = 3'd4,
    PC_OP_IRQ  = 3'd5,
    PC_OP_HLD0 = 3'd6,
    PC_OP_HLD1 = 3'd7
  } pc_op_e;
endpackage

// File: rtl/pcu_latch.sv
module pcu_latch #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/pcu_stack.sv
// Circular LIFO; DEPTH must be a power of two so the pointer wraps naturally.
module pcu_stack #(
  parameter int unsigned W     = 13,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] top_idx;

  assign top_idx = ptr_q - PTR_W'(1);
  assign dout_o  = mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[ptr_q] <= din_i;
      ptr_q        <= ptr_q + PTR_W'(1);
    end else if (pop_i) begin
      ptr_q <= top_idx;
    end
  end
endmodule

// File: rtl/pcu_next.sv
module pcu_next
  import pcu_pkg::*;
#(
  parameter int unsigned PC_W     = 13,
  parameter int unsigned TGT_W    = 11,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned VEC_ADDR = 4,
  localparam int unsigned LATCH_W = PC_W - DATA_W,
  localparam int unsigned PAGE_W  = PC_W - TGT_W,
  localparam int unsigned PAGE_LO = TGT_W - DATA_W
) (
  input  logic [2:0]         op_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [TGT_W-1:0]   tgt_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [LATCH_W-1:0] latch_i,
  input  logic [PC_W-1:0]    pop_data_i,
  output logic [PC_W-1:0]    pc_nxt_o,
  output logic               push_o,
  output logic               pop_o,
  output logic [PC_W-1:0]    push_data_o
);
  pc_op_e            op;
  logic [PC_W-1:0]   pc_inc;
  logic [PC_W-1:0]   pc_far;

  assign op     = pc_op_e'(op_i);
  assign pc_inc = pc_i + PC_W'(1);
  assign pc_far = {latch_i[PAGE_LO +: PAGE_W], tgt_i};

  always_comb begin
    pc_nxt_o    = pc_i;
    push_o      = 1'b0;
    pop_o       = 1'b0;
    push_data_o = pc_inc;
    unique case (op)
      PC_OP_INC:  pc_nxt_o = pc_inc;
      PC_OP_JMP:  pc_nxt_o = pc_far;
      PC_OP_CALL: begin
        pc_nxt_o = pc_far;
        push_o   = 1'b1;
      end
      PC_OP_RET: begin
        pc_nxt_o = pop_data_i;
        pop_o    = 1'b1;
      end
      PC_OP_WRLO: pc_nxt_o = {latch_i, data_i};
      PC_OP_IRQ: begin
        pc_nxt_o    = PC_W'(VEC_ADDR);
        push_o      = 1'b1;
        push_data_o = pc_i;
      end
      default:    pc_nxt_o = pc_i;
    endcase
  end
endmodule

// File: rtl/prog_ctr_unit.sv
module prog_ctr_unit #(
  parameter int unsigned PC_W     = 13,
  parameter int unsigned TGT_W    = 11,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned VEC_ADDR = 4,
  localparam int unsigned LATCH_W = PC_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [TGT_W-1:0]  tgt_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              latch_we_i,
  output logic [PC_W-1:0]   pc_o
);
  logic [LATCH_W-1:0] latch_q;
  logic [PC_W-1:0]    pc_q, pc_nxt, pop_data, push_data;
  logic               push, pop;

  pcu_latch #(.W(LATCH_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (latch_we_i),
    .d_i    (data_i[LATCH_W-1:0]),
    .q_o    (latch_q)
  );

  pcu_next #(
    .PC_W(PC_W), .TGT_W(TGT_W), .DATA_W(DATA_W), .VEC_ADDR(VEC_ADDR)
  ) u_next (
    .op_i        (op_i),
    .pc_i        (pc_q),
    .tgt_i       (tgt_i),
    .data_i      (data_i),
    .latch_i     (latch_q),
    .pop_data_i  (pop_data),
    .pc_nxt_o    (pc_nxt),
    .push_o      (push),
    .pop_o       (pop),
    .push_data_o (push_data)
  );

  pcu_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .din_i  (push_data),
    .dout_o (pop_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_nxt;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pcu_chk.sv
module pcu_chk
  import pcu_pkg::*;
#(
  parameter int unsigned PC_W     = 13,
  parameter int unsigned TGT_W    = 11,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned VEC_ADDR = 4,
  localparam int unsigned LATCH_W = PC_W - DATA_W,
  localparam int unsigned PAGE_W  = PC_W - TGT_W,
  localparam int unsigned PAGE_LO = TGT_W - DATA_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2:0]         op_i,
  input logic [TGT_W-1:0]   tgt_i,
  input logic [DATA_W-1:0]  data_i,
  input logic               latch_we_i,
  input logic [PC_W-1:0]    pc_o,
  input logic [LATCH_W-1:0] latch_q
);
  AST_RESET_PC: assert property (@(posedge clk_i) !rst_ni |-> pc_o == '0); // R1

  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == PC_OP_INC |=> pc_o == $past(pc_o) + PC_W'(1)); // R2

  AST_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == PC_OP_JMP |=> pc_o == {$past(latch_q[PAGE_LO +: PAGE_W]), $past(tgt_i)}); // R3

  AST_CALL_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == PC_OP_CALL) ##1 (op_i == PC_OP_RET) |=> pc_o == $past(pc_o, 2) + PC_W'(1)); // R5

  AST_WRLO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == PC_OP_WRLO |=> pc_o == {$past(latch_q), $past(data_i)}); // R6

  AST_IRQ_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == PC_OP_IRQ |=> pc_o == PC_W'(VEC_ADDR)); // R7

  AST_LATCH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_we_i |=> latch_q == $past(data_i[LATCH_W-1:0])); // R8

  AST_LATCH_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_we_i |=> $stable(latch_q)); // R8

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == PC_OP_HLD0 || op_i == PC_OP_HLD1) |=> $stable(pc_o)); // R10
endmodule

bind prog_ctr_unit pcu_chk #(
  .PC_W(PC_W), .TGT_W(TGT_W), .DATA_W(DATA_W), .VEC_ADDR(VEC_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_i       (op_i),
  .tgt_i      (tgt_i),
  .data_i     (data_i),
  .latch_we_i (latch_we_i),
  .pc_o       (pc_o),
  .latch_q    (latch_q)
);

// File: tb/prog_ctr_unit_tb.sv
`timescale 1ns/1ps
module prog_ctr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd6;
  logic [10:0] tgt = '0;
  logic [7:0]  dat = '0;
  logic        lwe = 1'b0;
  logic [12:0] pc;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [12:0] m_pc = '0;
  logic [4:0]  m_latch = '0;
  logic [12:0] m_stk [8];
  int          m_sp = 0;

  always #2.5 clk = ~clk;

  prog_ctr_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .tgt_i(tgt),
    .data_i(dat), .latch_we_i(lwe), .pc_o(pc)
  );

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pc_o=%h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [10:0] t, input logic [7:0] d, input bit we);
    logic [12:0] nxt;
    @(negedge clk);
    op = o; tgt = t; dat = d; lwe = we;
    nxt = m_pc;
    case (o)
      3'd0: nxt = m_pc + 13'd1;
      3'd1: nxt = {m_latch[4:3], t};
      3'd2: begin m_stk[m_sp] = m_pc + 13'd1; m_sp = (m_sp + 1) % 8; nxt = {m_latch[4:3], t}; end
      3'd3: begin m_sp = (m_sp + 7) % 8; nxt = m_stk[m_sp]; end
      3'd4: nxt = {m_latch, d};
      3'd5: begin m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8; nxt = 13'h004; end
      default: nxt = m_pc;
    endcase
    if (we) m_latch = d[4:0];
    m_pc = nxt;
    @(posedge clk); #1;
    op = 3'd6; lwe = 1'b0;
  endtask

  task automatic set_latch(input logic [4:0] v);
    step(3'd6, '0, {3'b0, v}, 1'b1);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: pc_o=%h expected run to finish", pc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    repeat (3) @(posedge clk);
    #1 check("R1 reset pc", pc, 13'h000);
    @(negedge clk) rst_n = 1'b1;
    // R1: return straight after reset gives a cleared entry
    step(3'd3, '0, '0, 0); check("R1 cleared stack", pc, m_pc);
    step(3'd4, '0, 8'h00, 0); check("R1 latch zero", pc, 13'h000);

    // R2: step across wrap
    set_latch(5'h1F);
    step(3'd4, '0, 8'hF8, 0); check("R6 wrlo", pc, 13'h1FF8);
    for (int i = 0; i < 12; i++) begin
      step(3'd0, '0, '0, 0); check("R2 step", pc, m_pc);
    end
    check("R2 wrapped", pc, 13'h0004);

    // R3 / R8: branch for every latch value and several targets
    for (int l = 0; l < 32; l++) begin
      set_latch(5'(l));
      for (int k = 0; k < 4; k++) begin
        step(3'd1, 11'((k * 11'h2A5 + l) & 11'h7FF), '0, 0);
        check("R3 branch", pc, m_pc);
      end
    end

    // R6: low-byte write for every latch value
    for (int l = 0; l < 32; l++) begin
      set_latch(5'(l));
      step(3'd4, '0, 8'(l * 7 + 3), 0); check("R6 wrlo sweep", pc, m_pc);
    end

    // R8: latch write in same cycle as wrlo uses old latch
    set_latch(5'h05);
    step(3'd4, '0, 8'h1A, 1); check("R8 old latch used", pc, 13'h051A);
    step(3'd4, '0, 8'h33, 0); check("R8 new latch", pc, {5'h1A, 8'h33});

    // R4/R5: nested calls of depth 1..8
    for (int d = 1; d <= 8; d++) begin
      for (int c = 0; c < d; c++) begin
        set_latch(5'(c * 8 + d));
        step(3'd2, 11'(c * 100 + d), '0, 0); check("R4 call", pc, m_pc);
      end
      for (int c = 0; c < d; c++) begin
        step(3'd3, '0, '0, 0); check("R5 return", pc, m_pc);
      end
    end
    // R8: push/pop left latch alone
    step(3'd4, '0, 8'hA5, 0); check("R8 latch kept over stack", pc, {m_latch, 8'hA5});

    // R9: ten calls, ten returns
    set_latch(5'h10);
    step(3'd4, '0, 8'h00, 0);
    for (int c = 0; c < 10; c++) begin
      step(3'd2, 11'(c * 16 + 1), '0, 0); check("R9 push", pc, m_pc);
    end
    for (int c = 0; c < 10; c++) begin
      step(3'd3, '0, '0, 0); check("R9 wrapped pop", pc, m_pc);
    end

    // R7: interrupt pushes current pc
    set_latch(5'h0C);
    step(3'd4, '0, 8'h77, 0);
    step(3'd5, '0, '0, 0); check("R7 vector", pc, 13'h004);
    step(3'd0, '0, '0, 0);
    step(3'd3, '0, '0, 0); check("R7 resume", pc, 13'h0C77);

    // R10: hold codes keep pc and stack
    step(3'd2, 11'h123, '0, 0);
    step(3'd6, '0, '0, 0); check("R10 hold6", pc, m_pc);
    step(3'd7, '0, '0, 0); check("R10 hold7", pc, m_pc);
    step(3'd3, '0, '0, 0); check("R10 stack intact", pc, 13'h0C78);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule